// File: doc/BRIEF.md
# Channel Command Decoder and Drive Director

This block sits behind a parallel host channel in a disk controller. The host issues a command by placing a command word (Q) and a data word (A) on the channel and raising one of two strobes. The output strobe carries a command from host to controller. The input strobe asks the controller for a clear or a status word. The block ignores any command that is addressed to another piece of equipment. For a command addressed to it, the block decides whether the command can run, from the function code, the transfer activity, the state of the selected drive and the protect rules. It answers with a single reply pulse or a single reject pulse after a fixed delay.

An accepted command pulses one decoded function strobe in the cycle of its reply. The downstream transfer, seek and status logic uses these strobes. The director command is handled inside the block. It holds the one-hot drive selection and three interrupt enables. The block also drives the interrupt line from the enables and the status flags.

The block has no data stream and therefore no valid/ready interface. The strobe and the reply or reject form the only handshake. Q and A must be valid at the clock edge where a strobe is first seen high. The host must not start a new command until the response pulse has been seen. A strobe that rises while a command is still waiting for its response is dropped. The block applies no other back-pressure.

Top module: `chan_cmd_director`

## Requirements
- R1: The block responds to a strobe only when Q bits 10:7 equal `equip_id` and Q bits 15:11 are all zero. In every other case it produces no reply, no reject, no function strobe and no change to the selection or to the enables.
- R2: For each captured command, exactly one of `reply` or `reject` is high, for one cycle. It appears DLY cycles after the clock edge that first sees the strobe high, with DLY = ceil(REPLY_NS / CLK_PERIOD_NS), which is 20 by default. A strobe that rises while a command is waiting for its response is ignored.
- R3: Output codes 000 (buffer length), 010 (load address), 011 (write), 100 (read), 101 (compare), 110 (checkword check) and 111 (write address) are accepted only when all of the following hold: `xfer_active` is low, a drive is selected, the selected drive is ready, the selected drive is on cylinder and not seeking, and the protect rule passes. Otherwise they are rejected.
- R4: The protect rule passes when the selected drive's `drv_protect` bit is low, or when `chan_protect` is high. With no drive selected, the rule passes.
- R5: The director command (output code 001) is accepted when `xfer_active` is low and the protect rule passes, whatever the ready, cylinder and seek state of the drives.
- R6: In an accepted director command, A bit 8 selects drive A[10:9]. The selection is one-hot in `unit_sel`, and A bit 10 is the MSB of the drive number. A bit 7 clears the selection. When bits 7 and 8 are both set, the selection is cleared. `unit_sel` changes only in a reply cycle.
- R7: In an accepted director command, A bits 2, 3 and 4 set `irq_en[0]` (ready and not busy), `irq_en[1]` (end of operation) and `irq_en[2]` (alarm). A bit 1 clears all three enables, but only when A bits 4:2 are all zero.
- R8: `irq` is the OR of (`irq_en[0]` AND `st_ready_nb`), (`irq_en[1]` AND `st_eop`) and (`irq_en[2]` AND `st_alarm`).
- R9: Input code 000 is accepted and clears both the selection and the enables. Input codes 001 to 101 are accepted. Input codes 110 and 111 are rejected.
- R10: An accepted output or input command pulses bit [code] of `out_fn_stb` or `in_fn_stb` in its reply cycle. A rejected command pulses no function strobe. The selection and enable updates become visible in that same reply cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| equip_id | input | 4 | Board equipment number |
| q_word | input | 16 | Command word: W field 15:11, equipment 10:7, code 2:0 |
| a_word | input | 16 | Data word (director payload) |
| out_stb | input | 1 | Output-command strobe |
| in_stb | input | 1 | Input-command strobe |
| chan_protect | input | 1 | Channel protect signal |
| xfer_active | input | 1 | A transfer-type operation is in progress |
| drv_ready | input | N_DRV | Per-drive ready |
| drv_oncyl | input | N_DRV | Per-drive on cylinder |
| drv_seek | input | N_DRV | Per-drive seeking |
| drv_protect | input | N_DRV | Per-drive protected |
| st_ready_nb | input | 1 | Status: controller ready and not busy |
| st_eop | input | 1 | Status: end of operation |
| st_alarm | input | 1 | Status: alarm |
| reply | output | 1 | Accept pulse |
| reject | output | 1 | Reject pulse |
| out_fn_stb | output | 8 | One-hot strobe for an accepted output code |
| in_fn_stb | output | 8 | One-hot strobe for an accepted input code |
| unit_sel | output | N_DRV | One-hot drive selection, zero when none |
| irq_en | output | 3 | Interrupt enables: ready/not busy, end of op, alarm |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in the same cycle. A director command changes the interrupt enables on its reply edge, while the status flags already hold values that the new enables gate. The bench raises the status flags before it issues enable and clear director commands. It then judges `irq` right after the reply edge against its own model of the updated enables. A second meeting comes from a strobe that rises while a response is still pending. The bench confirms that only the first command is answered, and that the second leaves the selection untouched.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;
  localparam int N_FN  = 8;
  localparam int FC_W  = 3;
  localparam int WORD_W = 16;

  // command word layout (decoded by the channel side)
  localparam int Q_EQ_LO = 7;
  localparam int Q_EQ_HI = 10;
  localparam int Q_W_LO  = 11;
  localparam int Q_W_HI  = 15;

  // director payload bit positions
  localparam int DIR_CLR_EN  = 1;
  localparam int DIR_EN_LO   = 2;
  localparam int DIR_EN_HI   = 4;
  localparam int DIR_DESEL   = 7;
  localparam int DIR_SEL     = 8;
  localparam int DIR_CODE_LO = 9;
  localparam int DIR_CODE_HI = 10;

  typedef enum logic [FC_W-1:0] {
    OP_BUF_LEN   = 3'd0,
    OP_DIRECT    = 3'd1,
    OP_LOAD_ADDR = 3'd2,
    OP_WRITE     = 3'd3,
    OP_READ      = 3'd4,
    OP_COMPARE   = 3'd5,
    OP_CHK_CHECK = 3'd6,
    OP_WRITE_ADR = 3'd7
  } out_op_e;

  localparam logic [FC_W-1:0] IN_CLEAR       = 3'd0;
  localparam logic [FC_W-1:0] IN_LAST_STATUS = 3'd5;

  typedef struct packed {
    logic              is_out;
    logic [FC_W-1:0]   code;
    logic              ok;
    logic [WORD_W-1:0] a;
  } cmd_t;
endpackage

// File: rtl/cc_accept.sv
module cc_accept
  import chan_cmd_pkg::*;
#(
  parameter int N_DRV = 4
) (
  input  logic             is_out,
  input  logic [FC_W-1:0]  code,
  input  logic [N_DRV-1:0] unit_sel,
  input  logic [N_DRV-1:0] drv_ready,
  input  logic [N_DRV-1:0] drv_oncyl,
  input  logic [N_DRV-1:0] drv_seek,
  input  logic [N_DRV-1:0] drv_protect,
  input  logic             chan_protect,
  input  logic             xfer_active,
  output logic             ok
);
  logic any_sel, sel_ready, sel_oncyl, sel_seek, sel_prot;
  logic prot_ok, dir_ok, op_ok, in_ok;

  always_comb begin
    any_sel   = |unit_sel;
    sel_ready = |(unit_sel & drv_ready);
    sel_oncyl = |(unit_sel & drv_oncyl);
    sel_seek  = |(unit_sel & drv_seek);
    sel_prot  = |(unit_sel & drv_protect);
    prot_ok   = !sel_prot || chan_protect;
    dir_ok    = !xfer_active && prot_ok;
    op_ok     = !xfer_active && any_sel && sel_ready && sel_oncyl &&
                !sel_seek && prot_ok;
    in_ok     = (code <= IN_LAST_STATUS);
    if (!is_out)                  ok = in_ok;
    else if (code == OP_DIRECT)   ok = dir_ok;
    else                          ok = op_ok;
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import chan_cmd_pkg::*;
#(
  parameter int DLY_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  cmd_t            start_cmd,
  output logic            pending,
  output logic            fire,
  output cmd_t            cur_cmd,
  output logic            reply,
  output logic            reject,
  output logic [N_FN-1:0] out_fn_stb,
  output logic [N_FN-1:0] in_fn_stb
);
  localparam int CNT_W = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DLY_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [N_FN-1:0]  code_hot;

  assign fire     = pending && (cnt == '0);
  assign code_hot = N_FN'(1) << cur_cmd.code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      cnt        <= '0;
      cur_cmd    <= '0;
      reply      <= 1'b0;
      reject     <= 1'b0;
      out_fn_stb <= '0;
      in_fn_stb  <= '0;
    end else begin
      reply      <= fire && cur_cmd.ok;
      reject     <= fire && !cur_cmd.ok;
      out_fn_stb <= (fire && cur_cmd.ok && cur_cmd.is_out)  ? code_hot : '0;
      in_fn_stb  <= (fire && cur_cmd.ok && !cur_cmd.is_out) ? code_hot : '0;
      if (start) begin
        pending <= 1'b1;
        cnt     <= LOAD;
        cur_cmd <= start_cmd;
      end else if (fire) begin
        pending <= 1'b0;
      end else if (pending) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cc_director.sv
module cc_director
  import chan_cmd_pkg::*;
#(
  parameter int N_DRV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  cmd_t             cmd,
  input  logic             st_ready_nb,
  input  logic             st_eop,
  input  logic             st_alarm,
  output logic [N_DRV-1:0] unit_sel,
  output logic [2:0]       irq_en,
  output logic             irq
);
  logic [N_DRV-1:0] sel_decoded;
  logic [1:0]       sel_code;
  logic [2:0]       en_req;
  logic             is_dir, is_clear;

  always_comb begin
    sel_code = cmd.a[DIR_CODE_HI:DIR_CODE_LO];
    en_req   = cmd.a[DIR_EN_HI:DIR_EN_LO];
    for (int i = 0; i < N_DRV; i++)
      sel_decoded[i] = (int'(sel_code) == i);
    is_dir   = fire && cmd.ok && cmd.is_out && (cmd.code == OP_DIRECT);
    is_clear = fire && cmd.ok && !cmd.is_out && (cmd.code == IN_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_sel <= '0;
      irq_en   <= '0;
    end else if (is_clear) begin
      unit_sel <= '0;
      irq_en   <= '0;
    end else if (is_dir) begin
      if (cmd.a[DIR_DESEL])     unit_sel <= '0;
      else if (cmd.a[DIR_SEL])  unit_sel <= sel_decoded;
      if (|en_req)              irq_en <= irq_en | en_req;
      else if (cmd.a[DIR_CLR_EN]) irq_en <= '0;
    end
  end

  assign irq = (irq_en[0] && st_ready_nb) ||
               (irq_en[1] && st_eop) ||
               (irq_en[2] && st_alarm);
endmodule

// File: rtl/chan_cmd_director.sv
module chan_cmd_director
  import chan_cmd_pkg::*;
#(
  parameter int N_DRV         = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int REPLY_NS      = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       equip_id,
  input  logic [15:0]      q_word,
  input  logic [15:0]      a_word,
  input  logic             out_stb,
  input  logic             in_stb,
  input  logic             chan_protect,
  input  logic             xfer_active,
  input  logic [N_DRV-1:0] drv_ready,
  input  logic [N_DRV-1:0] drv_oncyl,
  input  logic [N_DRV-1:0] drv_seek,
  input  logic [N_DRV-1:0] drv_protect,
  input  logic             st_ready_nb,
  input  logic             st_eop,
  input  logic             st_alarm,
  output logic             reply,
  output logic             reject,
  output logic [7:0]       out_fn_stb,
  output logic [7:0]       in_fn_stb,
  output logic [N_DRV-1:0] unit_sel,
  output logic [2:0]       irq_en,
  output logic             irq
);
  localparam int DLY_CYC = (REPLY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic out_q, in_q;
  logic rise_out, rise_in, addressed, start, pending, fire, cmd_ok;
  cmd_t new_cmd, cur_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      in_q  <= 1'b0;
    end else begin
      out_q <= out_stb;
      in_q  <= in_stb;
    end
  end

  always_comb begin
    rise_out  = out_stb && !out_q;
    rise_in   = in_stb && !in_q && !rise_out;
    addressed = (q_word[Q_EQ_HI:Q_EQ_LO] == equip_id) &&
                (q_word[Q_W_HI:Q_W_LO] == '0);
    start     = (rise_out || rise_in) && addressed && !pending;
    new_cmd.is_out = rise_out;
    new_cmd.code   = q_word[FC_W-1:0];
    new_cmd.ok     = cmd_ok;
    new_cmd.a      = a_word;
  end

  cc_accept #(.N_DRV(N_DRV)) u_accept (
    .is_out(rise_out), .code(q_word[FC_W-1:0]), .unit_sel(unit_sel),
    .drv_ready(drv_ready), .drv_oncyl(drv_oncyl), .drv_seek(drv_seek),
    .drv_protect(drv_protect), .chan_protect(chan_protect),
    .xfer_active(xfer_active), .ok(cmd_ok)
  );

  cc_timer #(.DLY_CYC(DLY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(new_cmd),
    .pending(pending), .fire(fire), .cur_cmd(cur_cmd),
    .reply(reply), .reject(reject),
    .out_fn_stb(out_fn_stb), .in_fn_stb(in_fn_stb)
  );

  cc_director #(.N_DRV(N_DRV)) u_director (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cur_cmd),
    .st_ready_nb(st_ready_nb), .st_eop(st_eop), .st_alarm(st_alarm),
    .unit_sel(unit_sel), .irq_en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/chan_cmd_director_chk.sv
module chan_cmd_director_chk #(
  parameter int N_DRV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reply,
  input logic             reject,
  input logic [7:0]       out_fn_stb,
  input logic [7:0]       in_fn_stb,
  input logic [N_DRV-1:0] unit_sel,
  input logic [2:0]       irq_en,
  input logic             irq
);
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !(reply && reject)); // R2
  AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reply |=> !reply); // R2
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject); // R2
  AST_FN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_fn_stb, in_fn_stb})); // R10
  AST_FN_NEEDS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|{out_fn_stb, in_fn_stb}) |-> reply); // R10
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_sel)); // R6
  AST_SEL_ON_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_sel) |-> reply); // R6
  AST_EN_ON_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_en) |-> reply); // R7
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 3'b000) |-> !irq); // R8
endmodule

bind chan_cmd_director chan_cmd_director_chk #(.N_DRV(N_DRV)) u_chk (
  .clk(clk), .rst_n(rst_n), .reply(reply), .reject(reject),
  .out_fn_stb(out_fn_stb), .in_fn_stb(in_fn_stb),
  .unit_sel(unit_sel), .irq_en(irq_en), .irq(irq)
);

// File: tb/chan_cmd_director_bench.sv
`timescale 1ns/1ps
module chan_cmd_director_bench;
  localparam int DLY = 20;
  localparam logic [3:0] EQ = 4'hA;

  logic clk = 0, rst_n = 0;
  logic [3:0] equip_id = EQ;
  logic [15:0] q_word = 0, a_word = 0;
  logic out_stb = 0, in_stb = 0, chan_protect = 0, xfer_active = 0;
  logic [3:0] drv_ready = 4'hF, drv_oncyl = 4'hF, drv_seek = 0, drv_protect = 0;
  logic st_ready_nb = 0, st_eop = 0, st_alarm = 0;
  logic reply, reject, irq;
  logic [7:0] out_fn_stb, in_fn_stb;
  logic [3:0] unit_sel;
  logic [2:0] irq_en;

  int checks = 0, errors = 0;
  logic [3:0] m_sel = 0;
  logic [2:0] m_en = 0;

  always #10 clk = ~clk;

  chan_cmd_director u_chan_cmd_director (
    .clk, .rst_n, .equip_id, .q_word, .a_word, .out_stb, .in_stb,
    .chan_protect, .xfer_active, .drv_ready, .drv_oncyl, .drv_seek,
    .drv_protect, .st_ready_nb, .st_eop, .st_alarm, .reply, .reject,
    .out_fn_stb, .in_fn_stb, .unit_sel, .irq_en, .irq
  );

  task automatic chk(input logic cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_q(input logic [4:0] w, input logic [3:0] eq, input logic [2:0] code);
    return {w, eq, 4'b0000, code};
  endfunction

  function automatic logic model_ok(input logic is_out, input logic [2:0] code);
    logic anysel = 0, rdy = 0, cyl = 0, sk = 0, pr = 0, prot_pass;
    for (int i = 0; i < 4; i++) if (m_sel[i]) begin
      anysel = 1; rdy = drv_ready[i]; cyl = drv_oncyl[i];
      sk = drv_seek[i]; pr = drv_protect[i];
    end
    prot_pass = !pr || chan_protect;
    if (!is_out) return code < 3'd6;                           // R9
    if (code == 3'd1) return !xfer_active && prot_pass;        // R5
    return !xfer_active && anysel && rdy && cyl && !sk && prot_pass; // R3
  endfunction

  task automatic model_apply(input logic is_out, input logic [2:0] code, input logic [15:0] a);
    if (!is_out && code == 0) begin m_sel = 0; m_en = 0; end
    if (is_out && code == 1) begin
      if (a[7]) m_sel = 0;
      else if (a[8]) m_sel = 4'b0001 << a[10:9];
      if (|a[4:2]) m_en = m_en | a[4:2];
      else if (a[1]) m_en = 0;
    end
  endtask

  // issue one command, judge timing, verdict, strobes and state
  task automatic do_cmd(input logic is_out, input logic [15:0] q, input logic [15:0] a, input string req);
    logic hit, ok, early;
    logic [7:0] exp_fn;
    hit = (q[10:7] == EQ) && (q[15:11] == 0);
    ok = model_ok(is_out, q[2:0]);
    early = 0;
    @(negedge clk);
    q_word = q; a_word = a;
    if (is_out) out_stb = 1; else in_stb = 1;
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk);
      if (i == 1) begin out_stb = 0; in_stb = 0; end
      if (reply || reject) early = 1;
    end
    @(negedge clk);
    chk(!early, {req, " R2 early response"}, early, 0);
    if (hit) begin
      if (ok) model_apply(is_out, q[2:0], a);
      exp_fn = ok ? (8'h01 << q[2:0]) : 8'h00;
      chk(reply == ok && reject == !ok, {req, " verdict R2"}, {reply, reject}, {ok, !ok});
      chk((is_out ? out_fn_stb : in_fn_stb) == exp_fn && (is_out ? in_fn_stb : out_fn_stb) == 0,
          {req, " strobe R10"}, {out_fn_stb, in_fn_stb}, exp_fn);
    end else begin
      chk(!reply && !reject && out_fn_stb == 0 && in_fn_stb == 0,
          {req, " ignored R1"}, {reply, reject}, 0);
    end
    chk(unit_sel == m_sel, {req, " unit_sel R6"}, unit_sel, m_sel);
    chk(irq_en == m_en, {req, " irq_en R7"}, irq_en, m_en);
    @(negedge clk);
    chk(!reply && !reject, {req, " single pulse R2"}, {reply, reject}, 0);
  endtask

  task automatic chk_irq(input logic r, input logic e, input logic al, input string req);
    logic exp;
    @(negedge clk);
    st_ready_nb = r; st_eop = e; st_alarm = al;
    #2;
    exp = (m_en[0] & r) | (m_en[1] & e) | (m_en[2] & al);
    chk(irq == exp, req, irq, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    repeat (3) @(negedge clk);
    chk(!reply && !reject && unit_sel == 0 && irq_en == 0 && !irq, "reset R2", {reply, reject}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: no drive selected -> read rejected
    do_cmd(1, mk_q(0, EQ, 3'd4), 0, "R3 no unit");
    // R6: select drive 2
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0500, "R6 select");
    // R6: de-select wins over select
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0780, "R6 clear wins");
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0300, "R6 select 1");
    // R4: protected drive without channel protect
    drv_protect = 4'b0010;
    do_cmd(1, mk_q(0, EQ, 3'd4), 0, "R4 protected reject");
    chan_protect = 1;
    do_cmd(1, mk_q(0, EQ, 3'd4), 0, "R4 protected pass");
    chan_protect = 0; drv_protect = 0;
    // R5: director accepted while seeking, rejected while transferring
    drv_seek = 4'b0010;
    do_cmd(1, mk_q(0, EQ, 3'd3), 0, "R3 seeking reject");
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0000, "R5 seek ok");
    drv_seek = 0; xfer_active = 1;
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0100, "R5 xfer reject");
    xfer_active = 0;
    // R7 and R8: status present before enables change
    st_eop = 1; st_alarm = 1;
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h000A, "R7 clear yields");
    chk(irq == 1'b1, "R8 irq after enable", irq, 1);
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0002, "R7 clear");
    chk(irq == 1'b0, "R8 irq after clear", irq, 0);
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h001C, "R7 all enables");
    chk_irq(1, 0, 0, "R8 ready");
    chk_irq(0, 1, 0, "R8 eop");
    chk_irq(0, 0, 1, "R8 alarm");
    chk_irq(0, 0, 0, "R8 none");
    // R9 input codes
    do_cmd(0, mk_q(0, EQ, 3'd6), 0, "R9 illegal 6");
    do_cmd(0, mk_q(0, EQ, 3'd7), 0, "R9 illegal 7");
    do_cmd(0, mk_q(0, EQ, 3'd3), 0, "R9 status");
    do_cmd(0, mk_q(0, EQ, 3'd0), 0, "R9 clear");
    // R1 mismatches
    do_cmd(1, mk_q(0, EQ, 3'd1), 16'h0700, "R6 select 3");
    do_cmd(1, mk_q(0, 4'h3, 3'd1), 16'h0180, "R1 wrong equip");
    do_cmd(1, mk_q(5'h04, EQ, 3'd1), 16'h0180, "R1 W nonzero");

    // R2: second strobe during pending is dropped
    begin
      logic saw_extra = 0;
      @(negedge clk);
      q_word = mk_q(0, EQ, 3'd2); in_stb = 1;
      for (int i = 1; i <= DLY; i++) begin
        @(negedge clk);
        if (i == 1) in_stb = 0;
        if (i == 5) begin q_word = mk_q(0, EQ, 3'd1); a_word = 16'h0100; out_stb = 1; end
        if (i == 6) out_stb = 0;
      end
      @(negedge clk);
      chk(reply && in_fn_stb == 8'h04, "R2 first answered", in_fn_stb, 8'h04);
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (reply || reject) saw_extra = 1;
      end
      chk(!saw_extra, "R2 second ignored", saw_extra, 0);
      chk(unit_sel == m_sel, "R2 selection untouched", unit_sel, m_sel);
    end

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic is_out;
      logic [3:0] eq;
      logic [4:0] w;
      drv_ready    = 4'($urandom) | 4'($urandom);
      drv_oncyl    = 4'($urandom) | 4'($urandom);
      drv_seek     = 4'($urandom) & 4'($urandom);
      drv_protect  = 4'($urandom) & 4'($urandom);
      chan_protect = 1'($urandom);
      xfer_active  = ($urandom % 5) == 0;
      is_out       = ($urandom % 4) != 0;
      eq           = (($urandom % 8) == 0) ? 4'($urandom) : EQ;
      w            = (($urandom % 10) == 0) ? 5'($urandom) : 5'd0;
      do_cmd(is_out, mk_q(w, eq, 3'($urandom)), 16'($urandom), "rand R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule